// File: doc/BRIEF.md
# Break Input and Main Output Enable Controller

This block guards the output stage of a PWM timer against an external fault. A single break pin is checked against a chosen polarity. When break detection is on and the pin reaches its active level, the main output enable drops at once, without waiting for a clock edge. The enable comes back either through a software set request or, if automatic re-enable is selected, on the next timer update event once the fault has gone.

For each channel the block decides what the output pad sees. While the main enable is on, an enabled channel passes its PWM reference level. A channel that is switched off is either released to high impedance or held at its inactive level. While the main enable is off, the outputs are either released or driven to their idle levels.

In bidirectional mode, a detected fault also pulls the break pin low through an open-drain driver, so that devices sharing the fault line are told. Software ends this drive by setting a disarm flag. Hardware clears the flag once the synchronised break is seen inactive. Writes to break enable, break polarity, bidirectional mode and disarm act one clock cycle after the write.

Top module: `brk_moe_ctrl`

## Requirements
- R1: After reset: `moe`, `brk_active`, `disarmed` and `brk_pin_drive_low` are 0, and every `ch_oe` bit is 0.
- R2: The break is active when break enable is 1 and the pin level equals `cfg_brk_pol` (0 = active low, 1 = active high). `brk_active` shows the break after a two-flop synchroniser. With break enable at 0 the pin has no effect on `moe` or `brk_active`.
- R3: While an enabled break is active at the pin, `moe` is 0. When the pin becomes active, `moe` falls with no clock edge needed.
- R4: A `moe_set` pulse sets `moe` at the next clock edge. A `moe_clr` pulse clears it, and `moe_clr` wins over any set in the same cycle.
- R5: With `cfg_auto_en` = 1, `update_evt` sets `moe` at the next edge. With `cfg_auto_en` = 0, `update_evt` has no effect.
- R6: A break active at the pin wins over `moe_set` and over an automatic set in the same cycle, so `moe` stays 0.
- R7: With `moe` = 0: if `cfg_idle_drive` = 0, `ch_oe` = 0. If `cfg_idle_drive` = 1, a channel with `ch_en` = 1 has `ch_oe` = 1 and `ch_out` = `ch_idle_lvl`, and a channel with `ch_en` = 0 has `ch_oe` = 0.
- R8: With `moe` = 1 and `ch_en` = 0: if `cfg_run_drive` = 0, `ch_oe` = 0. If `cfg_run_drive` = 1, `ch_oe` = 1 and `ch_out` = `ch_inact_lvl`. Whenever `ch_oe` = 0, `ch_out` = 0.
- R9: With `moe` = 1 and `ch_en` = 1: `ch_oe` = 1 and `ch_out` = `ch_ref`.
- R10: With bidirectional mode on, a synchronised break latches a fault, and `brk_pin_drive_low` = 1 while that fault is held and `disarmed` = 0. With bidirectional mode off, the pin is never driven.
- R11: A `disarm_wr` pulse sets `disarmed` and releases the drive. Hardware clears `disarmed`, and the held fault, once the synchronised break is inactive.
- R12: Writes to break enable, break polarity and bidirectional mode (on `cfg_we`), and `disarm_wr` pulses, take effect one cycle after the edge that captures them. Writes to `cfg_auto_en`, `cfg_idle_drive` and `cfg_run_drive` take effect at the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_brk_en | input | 1 | Break detection enable |
| cfg_brk_pol | input | 1 | Break active level |
| cfg_auto_en | input | 1 | Re-enable on update event |
| cfg_idle_drive | input | 1 | Drive idle levels while `moe` = 0 |
| cfg_run_drive | input | 1 | Drive inactive level on disabled channels while `moe` = 1 |
| cfg_bidir | input | 1 | Open-drain fault signalling on the break pin |
| disarm_wr | input | 1 | Software request to release the pin drive |
| moe_set | input | 1 | Software set of the main enable |
| moe_clr | input | 1 | Software clear of the main enable |
| update_evt | input | 1 | Timer update event pulse |
| brk_pin_i | input | 1 | Break pin level as read |
| brk_pin_drive_low | output | 1 | Pull the break pin low |
| ch_en | input | NUM_CH | Per-channel output enable |
| ch_ref | input | NUM_CH | Per-channel PWM reference level |
| ch_idle_lvl | input | NUM_CH | Per-channel idle level |
| ch_inact_lvl | input | NUM_CH | Per-channel inactive level |
| ch_out | output | NUM_CH | Per-channel output value |
| ch_oe | output | NUM_CH | Per-channel output drive enable |
| moe | output | 1 | Main output enable |
| brk_active | output | 1 | Synchronised break status |
| disarmed | output | 1 | Disarm flag |

## Verification
The main collision is a break reaching the pin in the same cycle as a request to set `moe`, whether from `moe_set` or from `update_evt` with automatic re-enable on. The bench drives the fault level and the set request in the same low clock phase. It then expects `moe` to be 0 both before and after the next edge. A second overlap is the disarm request landing while the synchroniser still holds the pin's own low drive. Here `disarmed` must stay set until two edges after the pin returns high, and only then clear.

// File: rtl/brk_moe_pkg.sv
package brk_moe_pkg;
   typedef struct packed {
      logic brk_en;
      logic brk_pol;
      logic bidir;
   } brk_cfg_t;

   localparam brk_cfg_t BRK_CFG_RST = '{brk_en: 1'b0, brk_pol: 1'b0, bidir: 1'b0};
endpackage

// File: rtl/brk_sync_chain.sv
module brk_sync_chain #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("brk_sync_chain: STAGES must be at least 2");
      end
      if (STAGES == 2) begin : g_two
         logic s1, s2;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s1 <= RST_VAL;
               s2 <= RST_VAL;
            end else begin
               s1 <= d;
               s2 <= s1;
            end
         end
         assign q = s2;
      end else begin : g_many
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= {STAGES{RST_VAL}};
            else        sr <= {sr[STAGES-2:0], d};
         end
         assign q = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/moe_flag.sv
module moe_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic brk_raw,
   input  logic set_req,
   input  logic clr_req,
   output logic moe
);
   always_ff @(posedge clk or negedge rst_n or posedge brk_raw) begin
      if (!rst_n)       moe <= 1'b0;
      else if (brk_raw) moe <= 1'b0;
      else if (clr_req) moe <= 1'b0;
      else if (set_req) moe <= 1'b1;
   end

   AST_MOE_LOW_IN_BRK: assert property (@(posedge clk) disable iff (!rst_n)
      brk_raw |-> !moe); // R3
   AST_RISE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(moe) |-> $past(set_req) && !$past(clr_req)); // R4
   AST_NO_RISE_IN_BRK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(moe) |-> !$past(brk_raw)); // R6
endmodule

// File: rtl/brk_fault_ctrl.sv
module brk_fault_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic brk_sync,
   input  logic bidir,
   input  logic disarm_pend,
   output logic disarmed,
   output logic drive_low
);
   logic fault_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q  <= 1'b0;
         disarmed <= 1'b0;
      end else begin
         if (disarm_pend)            disarmed <= 1'b1;
         else if (!brk_sync)         disarmed <= 1'b0;
         if (brk_sync && bidir)      fault_q  <= 1'b1;
         else if (disarmed && !brk_sync) fault_q <= 1'b0;
      end
   end

   assign drive_low = bidir && fault_q && !disarmed;

   AST_DISARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(disarmed) |-> !$past(brk_sync)); // R11
endmodule

// File: rtl/out_state_sel.sv
module out_state_sel (
   input  logic clk,
   input  logic rst_n,
   input  logic moe,
   input  logic idle_drive,
   input  logic run_drive,
   input  logic en,
   input  logic ref_lvl,
   input  logic idle_lvl,
   input  logic inact_lvl,
   output logic out,
   output logic oe
);
   always_comb begin
      oe  = 1'b0;
      out = 1'b0;
      if (moe) begin
         if (en) begin
            oe  = 1'b1;
            out = ref_lvl;
         end else if (run_drive) begin
            oe  = 1'b1;
            out = inact_lvl;
         end
      end else if (idle_drive && en) begin
         oe  = 1'b1;
         out = idle_lvl;
      end
   end

   AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (!moe && !idle_drive) |-> !oe); // R7
   AST_RUN_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (moe && !en && !run_drive) |-> !oe); // R8
endmodule

// File: rtl/brk_moe_ctrl.sv
module brk_moe_ctrl
   import brk_moe_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit PIN_IDLE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_brk_en,
   input  logic              cfg_brk_pol,
   input  logic              cfg_auto_en,
   input  logic              cfg_idle_drive,
   input  logic              cfg_run_drive,
   input  logic              cfg_bidir,
   input  logic              disarm_wr,
   input  logic              moe_set,
   input  logic              moe_clr,
   input  logic              update_evt,
   input  logic              brk_pin_i,
   output logic              brk_pin_drive_low,
   input  logic [NUM_CH-1:0] ch_en,
   input  logic [NUM_CH-1:0] ch_ref,
   input  logic [NUM_CH-1:0] ch_idle_lvl,
   input  logic [NUM_CH-1:0] ch_inact_lvl,
   output logic [NUM_CH-1:0] ch_out,
   output logic [NUM_CH-1:0] ch_oe,
   output logic              moe,
   output logic              brk_active,
   output logic              disarmed
);
   localparam int CH_LAST = NUM_CH - 1;

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("brk_moe_ctrl: NUM_CH must be at least 1");
      end
   endgenerate

   brk_cfg_t cfg_q, cfg_eff;
   logic     auto_q, idle_q, run_q, disarm_pend;
   logic     pin_s, brk_raw, brk_sync, set_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q       <= BRK_CFG_RST;
         cfg_eff     <= BRK_CFG_RST;
         auto_q      <= 1'b0;
         idle_q      <= 1'b0;
         run_q       <= 1'b0;
         disarm_pend <= 1'b0;
      end else begin
         if (cfg_we) begin
            cfg_q  <= '{brk_en: cfg_brk_en, brk_pol: cfg_brk_pol, bidir: cfg_bidir};
            auto_q <= cfg_auto_en;
            idle_q <= cfg_idle_drive;
            run_q  <= cfg_run_drive;
         end
         cfg_eff     <= cfg_q;
         disarm_pend <= disarm_wr;
      end
   end

   brk_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(brk_pin_i), .q(pin_s)
   );

   assign brk_raw  = cfg_eff.brk_en && (brk_pin_i == cfg_eff.brk_pol);
   assign brk_sync = cfg_eff.brk_en && (pin_s == cfg_eff.brk_pol);
   assign set_req  = moe_set || (auto_q && update_evt);
   assign brk_active = brk_sync;

   moe_flag u_moe (
      .clk(clk), .rst_n(rst_n), .brk_raw(brk_raw),
      .set_req(set_req), .clr_req(moe_clr), .moe(moe)
   );

   brk_fault_ctrl u_fault (
      .clk(clk), .rst_n(rst_n), .brk_sync(brk_sync), .bidir(cfg_eff.bidir),
      .disarm_pend(disarm_pend), .disarmed(disarmed), .drive_low(brk_pin_drive_low)
   );

   generate
      for (genvar i = 0; i <= CH_LAST; i++) begin : g_ch
         out_state_sel u_sel (
            .clk(clk), .rst_n(rst_n), .moe(moe),
            .idle_drive(idle_q), .run_drive(run_q),
            .en(ch_en[i]), .ref_lvl(ch_ref[i]),
            .idle_lvl(ch_idle_lvl[i]), .inact_lvl(ch_inact_lvl[i]),
            .out(ch_out[i]), .oe(ch_oe[i])
         );
      end
   endgenerate

   AST_DRIVE_NEEDS_BIDIR: assert property (@(posedge clk) disable iff (!rst_n)
      brk_pin_drive_low |-> cfg_eff.bidir && !disarmed); // R10
   AST_STATUS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      brk_active |-> cfg_eff.brk_en); // R2
endmodule

// File: tb/brk_moe_ctrl_test.sv
module brk_moe_ctrl_test;
   localparam int N = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 0, cfg_brk_en = 0, cfg_brk_pol = 0, cfg_auto_en = 0;
   logic cfg_idle_drive = 0, cfg_run_drive = 0, cfg_bidir = 0;
   logic disarm_wr = 0, moe_set = 0, moe_clr = 0, update_evt = 0;
   logic ext_pin = 1'b1;
   logic brk_pin, drive_low;
   logic [N-1:0] ch_en = '0, ch_ref = '0, ch_idle = '0, ch_inact = '0;
   logic [N-1:0] ch_out, ch_oe;
   logic moe, brk_active, disarmed;
   int checks = 0, failures = 0;
   logic m_moe;

   assign brk_pin = ext_pin & ~drive_low;

   always #4 clk = ~clk;

   brk_moe_ctrl #(.NUM_CH(N)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_brk_en(cfg_brk_en),
      .cfg_brk_pol(cfg_brk_pol), .cfg_auto_en(cfg_auto_en),
      .cfg_idle_drive(cfg_idle_drive), .cfg_run_drive(cfg_run_drive),
      .cfg_bidir(cfg_bidir), .disarm_wr(disarm_wr), .moe_set(moe_set),
      .moe_clr(moe_clr), .update_evt(update_evt), .brk_pin_i(brk_pin),
      .brk_pin_drive_low(drive_low), .ch_en(ch_en), .ch_ref(ch_ref),
      .ch_idle_lvl(ch_idle), .ch_inact_lvl(ch_inact), .ch_out(ch_out),
      .ch_oe(ch_oe), .moe(moe), .brk_active(brk_active), .disarmed(disarmed)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [1:0] exp_ch(input logic m, input logic idl, input logic run,
                                         input logic en, input logic r, input logic il,
                                         input logic ia);
      // returns {oe, out}
      if (m) begin
         if (en)       return {1'b1, r};
         else if (run) return {1'b1, ia};
         else          return 2'b00;
      end
      if (idl && en) return {1'b1, il};
      return 2'b00;
   endfunction

   task automatic write_cfg(input logic en, input logic pol, input logic au,
                            input logic idl, input logic run, input logic bd);
      @(negedge clk);
      cfg_brk_en = en; cfg_brk_pol = pol; cfg_auto_en = au;
      cfg_idle_drive = idl; cfg_run_drive = run; cfg_bidir = bd;
      cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pulse_set();
      @(negedge clk); moe_set = 1'b1;
      @(negedge clk); moe_set = 1'b0;
   endtask

   task automatic wait_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      chk(1'b0, "WATCHDOG", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      // R1 reset state
      #3;
      chk(moe == 0 && ch_oe == '0, "R1 moe/oe in reset", {moe, ch_oe}, 0);
      wait_cycles(2);
      rst_n = 1'b1;
      wait_cycles(1);
      chk(moe == 0 && brk_active == 0 && disarmed == 0 && drive_low == 0 && ch_oe == '0,
          "R1 after reset", {moe, brk_active, disarmed, drive_low, ch_oe}, 0);

      // active-low break on, pin high
      write_cfg(1, 0, 0, 0, 0, 0);
      wait_cycles(3);
      pulse_set();
      chk(moe == 1, "R4 software set", moe, 1);
      @(negedge clk); moe_set = 1'b1; moe_clr = 1'b1;
      @(negedge clk); moe_set = 1'b0; moe_clr = 1'b0;
      chk(moe == 0, "R4 clear beats set", moe, 0);

      // R7 R8 R9 random output selection with moe model
      m_moe = moe;
      for (int it = 0; it < 60; it++) begin
         logic au, idl, run, s, c, u;
         au = $urandom() % 2; idl = $urandom() % 2; run = $urandom() % 2;
         write_cfg(1, 0, au, idl, run, 0);
         @(negedge clk);
         s = $urandom() % 2; c = ($urandom() % 4) == 0; u = $urandom() % 2;
         moe_set = s; moe_clr = c; update_evt = u;
         if (c) m_moe = 1'b0;
         else if (s || (au && u)) m_moe = 1'b1;
         @(negedge clk);
         moe_set = 0; moe_clr = 0; update_evt = 0;
         ch_en = N'($urandom()); ch_ref = N'($urandom());
         ch_idle = N'($urandom()); ch_inact = N'($urandom());
         #1;
         chk(moe == m_moe, "R4 R5 random moe", moe, m_moe);
         for (int i = 0; i < N; i++) begin
            logic [1:0] e;
            e = exp_ch(m_moe, idl, run, ch_en[i], ch_ref[i], ch_idle[i], ch_inact[i]);
            chk({ch_oe[i], ch_out[i]} == e, m_moe ? (ch_en[i] ? "R9 run enabled" : "R8 run disabled")
                : "R7 idle", {ch_oe[i], ch_out[i]}, e);
         end
      end

      // R5 update ignored without auto
      write_cfg(1, 0, 0, 1, 1, 0);
      @(negedge clk); moe_clr = 1; @(negedge clk); moe_clr = 0;
      @(negedge clk); update_evt = 1; @(negedge clk); update_evt = 0;
      chk(moe == 0, "R5 update without auto", moe, 0);
      write_cfg(1, 0, 1, 1, 1, 0);
      @(negedge clk); update_evt = 1; @(negedge clk); update_evt = 0;
      chk(moe == 1, "R5 update with auto", moe, 1);

      // R3 asynchronous clear, R2 synchronised status
      ch_en = '1; ch_ref = '1; ch_idle = '0;
      @(negedge clk); #1 ext_pin = 1'b0; #1;
      chk(moe == 0, "R3 async clear before edge", moe, 0);
      chk(ch_oe == '1 && ch_out == '0, "R7 idle after break", {ch_oe, ch_out}, 8'hF0);
      chk(brk_active == 0, "R2 status not yet synced", brk_active, 0);
      wait_cycles(2);
      chk(brk_active == 1, "R2 status after sync", brk_active, 1);
      // R6 collisions with break held
      @(negedge clk); moe_set = 1; update_evt = 1;
      @(negedge clk); moe_set = 0; update_evt = 0;
      chk(moe == 0, "R6 break beats set", moe, 0);
      ext_pin = 1'b1;
      wait_cycles(3);
      chk(brk_active == 0, "R2 status released", brk_active, 0);
      // R6 break arriving in the same cycle as set
      @(negedge clk); moe_set = 1; ext_pin = 1'b0;
      @(negedge clk); moe_set = 0; ext_pin = 1'b1;
      chk(moe == 0, "R6 same-cycle break and set", moe, 0);
      wait_cycles(3);

      // R12 polarity change takes one extra cycle; pin is high
      pulse_set();
      chk(moe == 1, "R4 set again", moe, 1);
      write_cfg(1, 1, 0, 0, 0, 0);
      chk(moe == 1, "R12 polarity not yet effective", moe, 1);
      @(negedge clk);
      chk(moe == 0, "R12 polarity effective, R2 active high", moe, 0);
      // R2 disabled break ignored
      write_cfg(0, 1, 0, 0, 0, 0);
      wait_cycles(1);
      pulse_set();
      ext_pin = 1'b0; #1; ext_pin = 1'b1;
      wait_cycles(3);
      chk(moe == 1 && brk_active == 0, "R2 disabled break ignored", {moe, brk_active}, 2);

      // R10 R11 bidirectional with disarm
      write_cfg(1, 0, 0, 0, 0, 1);
      wait_cycles(2);
      ext_pin = 1'b0;
      wait_cycles(3);
      ext_pin = 1'b1;
      wait_cycles(2);
      chk(drive_low == 1 && brk_active == 1, "R10 fault held on pin", {drive_low, brk_active}, 3);
      chk(moe == 0, "R3 moe low during driven fault", moe, 0);
      @(negedge clk); disarm_wr = 1;
      @(negedge clk); disarm_wr = 0;
      chk(disarmed == 0 && drive_low == 1, "R12 disarm delayed", {disarmed, drive_low}, 1);
      @(negedge clk);
      chk(disarmed == 1 && drive_low == 0, "R11 disarm releases", {disarmed, drive_low}, 2);
      @(negedge clk);
      chk(disarmed == 1, "R11 disarm held during sync", disarmed, 1);
      wait_cycles(3);
      chk(disarmed == 0 && drive_low == 0 && brk_active == 0, "R11 hardware clears disarm",
          {disarmed, drive_low, brk_active}, 0);
      // R10 no drive without bidirectional mode
      write_cfg(1, 0, 0, 0, 0, 0);
      wait_cycles(1);
      ext_pin = 1'b0;
      wait_cycles(3);
      ext_pin = 1'b1;
      wait_cycles(1);
      chk(drive_low == 0, "R10 no drive in input mode", drive_low, 0);
      wait_cycles(3);
      chk(brk_active == 0, "R2 released after input-mode fault", brk_active, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule